// File: doc/BRIEF.md
# I2C Configuration Target

This block is an I2C target that lets a bus controller load a small configuration register file. It watches SCL and SDA through synchronisers in the system clock domain. It drives SDA only through an open-drain enable, which pulls the line low while set.

The 7-bit bus address is fixed in its upper five bits, and the lower two bits come from strap pins. Software can therefore place up to four of these targets on one bus.

A write transfer carries pairs of bytes after the address byte. The first byte of a pair selects the register and the second is the value for it. There is no auto-increment, and pairs repeat until a stop. Each completed data byte produces a single-cycle write strobe toward the register file, together with the selected register and the value. A read transfer returns the value of the most recently selected register, repeated for as long as the controller acknowledges.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target answers to the 7-bit address whose bits 6..2 are 10110, whose bit 1 is `strap_addr[1]` and whose bit 0 is `strap_addr[0]`. The eighth bit of the address byte is the direction: 0 means write and 1 means read. On a match it acknowledges by pulling SDA low during the ninth clock.
- R2: On an address mismatch it leaves SDA released for the acknowledge clock. It then ignores all further bytes, issuing no strobe and giving no acknowledge, until the next start condition.
- R3: In a write, the byte after the address byte is a register selector and the next byte is data. Both are acknowledged. The selector appears on `reg_addr` once its eighth bit is taken. The completed data byte produces exactly one `wr_stb` pulse, lasting one cycle, with `wr_data` holding the byte.
- R4: Selector/data pairs repeat within one transfer in any order and number. Each pair uses only its own selector, with no auto-increment.
- R5: Only selectors 0x00, 0x01 and 0xF0 produce a strobe. Data for any other selector is still acknowledged but writes nothing.
- R6: In a read (direction bit 1), the target sends `rd_data` for the current `reg_addr`, MSB first. It sends the same register again after every controller ACK. After a controller NACK it releases SDA and stays silent until the next start.
- R7: A start or stop condition that arrives before the eighth bit of a byte abandons that byte. No strobe is issued and `reg_addr` is not changed. A repeated start begins a new address phase.
- R8: The SDA enable changes only while the synchronised SCL is low. The only exception is the release forced by a start or stop.
- R9: After reset `sda_oe` is 0, `wr_stb` is 0 and `reg_addr` is 0x00.
- R10: After a stop condition, bytes clocked without a new start are ignored: no acknowledge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_addr | input | 2 | Strap pins forming the two low address bits |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr | output | 8 | Currently selected register |
| wr_stb | output | 1 | One-cycle write strobe to the register file |
| wr_data | output | 8 | Data accompanying `wr_stb` |
| rd_data | input | 8 | Register file contents at `reg_addr` |

## Verification
The address phase is swept over all sixteen combinations of strap value and addressed low bits. This separates a correct match from a decoder that ignores either strap bit or inverts them, and each mismatch is followed by data bytes to prove they are ignored. Writes use a mixed run of pairs with repeated and out-of-order selectors plus an unsupported selector, which exposes auto-increment and missing address filtering. Reads with several ACKs and a final NACK, a read after a repeated start, and transfers cut off mid-byte by a repeated start or a stop separate correct byte completion from premature strobes or premature selector updates.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int STRAP_W = 2;
    localparam logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 5'b10110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SEL,
        ST_SEL_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    function automatic logic sel_writable(input logic [BYTE_W-1:0] sel);
        return (sel == 8'h00) || (sel == 8'h01) || (sel == 8'hF0);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
    end

endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import cfg_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_e          state;
    logic [BYTE_W-1:0]   shreg;
    logic [CNT_W-1:0]    bitcnt;
    logic                ctl_ack;
    logic [ADDR_W-1:0]   own_addr;
    logic                rx_state;

    assign own_addr = {ADDR_PREFIX, strap_addr};
    assign rx_state = (state == ST_ADDR) || (state == ST_SEL) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ctl_ack  <= 1'b0;
            sda_oe   <= 1'b0;
            reg_addr <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                if (evt.scl_rise && bitcnt != FULL) begin
                    shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                    bitcnt <= bitcnt + 1'b1;
                end else if (evt.scl_fall && bitcnt == FULL) begin
                    bitcnt <= '0;
                    unique case (state)
                        ST_ADDR: begin
                            if (shreg[BYTE_W-1:1] == own_addr) begin
                                sda_oe  <= 1'b1;
                                ctl_ack <= shreg[0];
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_SEL: begin
                            reg_addr <= shreg;
                            sda_oe   <= 1'b1;
                            state    <= ST_SEL_ACK;
                        end
                        default: begin
                            wr_data <= shreg;
                            wr_stb  <= sel_writable(reg_addr);
                            sda_oe  <= 1'b1;
                            state   <= ST_DATA_ACK;
                        end
                    endcase
                end
            end else begin
                unique case (state)
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (ctl_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_SEL;
                            end
                        end
                    end
                    ST_SEL_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_SEL;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == FULL) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            ctl_ack <= ~evt.sda;
                            bitcnt  <= 1;
                        end else if (evt.scl_fall && bitcnt == 1) begin
                            bitcnt <= '0;
                            if (ctl_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(evt.scl) || $past(evt.start) || $past(evt.stop)));

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R5
    stb_sel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (reg_addr == 8'h00 || reg_addr == 8'h01 || reg_addr == 8'hF0));

    // R7
    stb_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(evt.scl_fall) && !$past(evt.start) && !$past(evt.stop)));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R6
    tx_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX) |-> $stable(reg_addr));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_addr,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    input  logic [7:0] rd_data
);

    bus_evt_t evt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_cfg_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .strap_addr (strap_addr),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data)
    );

endmodule

// File: tb/test_cfg_i2c_target.sv
`timescale 1ns/1ps
module test_cfg_i2c_target;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    int r8_bad = 0;
    logic [7:0] m00 = 8'h00, m01 = 8'h00, mf0 = 8'h00;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfg_i2c_target i_cfg_i2c_target (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_addr (strap),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_data    (rd_data)
    );

    always_comb begin
        case (reg_addr)
            8'h00:   rd_data = m00;
            8'h01:   rd_data = m01;
            8'hF0:   rd_data = mf0;
            default: rd_data = 8'hEE;
        endcase
    end

    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt++;
            case (reg_addr)
                8'h00: m00 <= wr_data;
                8'h01: m01 <= wr_data;
                8'hF0: mf0 <= wr_data;
                default: ;
            endcase
        end
        if (!rst && sda_oe !== prev_oe && scl_m) r8_bad++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        wq(); sda_m = b;
        wq(); scl_m = 1'b1;
        wq(); wq(); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic s);
        wq(); sda_m = 1'b1;
        wq(); scl_m = 1'b1;
        wq(); s = sda_line;
        wq(); scl_m = 1'b0;
    endtask

    task automatic do_start();
        wq(); sda_m = 1'b1;
        wq(); scl_m = 1'b1;
        wq(); sda_m = 1'b0;
        wq(); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        wq(); sda_m = 1'b0;
        wq(); scl_m = 1'b1;
        wq(); sda_m = 1'b1;
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_in(s);
            b[i] = s;
        end
        bit_out(~give_ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] lo, input logic rd);
        return {5'b10110, lo, rd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] rb;
        int base;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 sda_oe", sda_oe == 1'b0, sda_oe, 0);
        chk("R9 wr_stb", wr_stb == 1'b0, wr_stb, 0);
        chk("R9 reg_addr", reg_addr == 8'h00, reg_addr, 0);

        // R1 / R2 full sweep of strap versus addressed low bits
        for (int s = 0; s < 4; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                logic [7:0] d;
                d = 8'(s * 16 + lo * 4 + 3);
                strap = 2'(s);
                base = stb_cnt;
                do_start();
                send_byte(addr_byte(2'(lo), 1'b0), a0);
                send_byte(8'h01, a1);
                send_byte(d, a2);
                do_stop();
                if (lo == s) begin
                    chk("R1 address ack", a0 == 1'b1, a0, 1);
                    chk("R3 selector and data ack", a1 && a2, {a1, a2}, 3);
                    chk("R3 one strobe", stb_cnt == base + 1, stb_cnt - base, 1);
                    chk("R3 data stored", m01 == d, m01, d);
                end else begin
                    chk("R2 no address ack", a0 == 1'b0, a0, 0);
                    chk("R2 later bytes ignored", !a1 && !a2 && stb_cnt == base,
                        stb_cnt - base, 0);
                end
            end
        end

        // R4 / R5 mixed pairs, no auto-increment
        strap = 2'd2;
        base = stb_cnt;
        do_start();
        send_byte(addr_byte(2'd2, 1'b0), a0);
        send_byte(8'hF0, a1); send_byte(8'hA5, a2);
        chk("R4 pair ack", a0 && a1 && a2, {a0, a1, a2}, 7);
        send_byte(8'h00, a1); send_byte(8'h3C, a2);
        send_byte(8'h02, a1); send_byte(8'h77, a2);
        chk("R5 unsupported selector still acked", a1 && a2, {a1, a2}, 3);
        send_byte(8'h01, a1); send_byte(8'hC3, a2);
        send_byte(8'h00, a1); send_byte(8'h81, a2);
        do_stop();
        chk("R5 strobes only for supported selectors", stb_cnt == base + 4, stb_cnt - base, 4);
        chk("R4 reg F0", mf0 == 8'hA5, mf0, 8'hA5);
        chk("R4 reg 00 last write wins", m00 == 8'h81, m00, 8'h81);
        chk("R4 reg 01", m01 == 8'hC3, m01, 8'hC3);

        // R6 read of selector F0 with ACK, ACK, NACK
        do_start();
        send_byte(addr_byte(2'd2, 1'b0), a0);
        send_byte(8'hF0, a1);
        do_stop();
        chk("R3 selector visible", reg_addr == 8'hF0, reg_addr, 8'hF0);
        do_start();
        send_byte(addr_byte(2'd2, 1'b1), a0);
        chk("R6 read address ack", a0 == 1'b1, a0, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k < 2, rb);
            chk("R6 read byte", rb == 8'hA5, rb, 8'hA5);
        end
        wq(); wq();
        chk("R6 released after NACK", sda_oe == 1'b0, sda_oe, 0);
        do_stop();

        // R6 read through repeated start
        do_start();
        send_byte(addr_byte(2'd2, 1'b0), a0);
        send_byte(8'h00, a1);
        do_start();
        send_byte(addr_byte(2'd2, 1'b1), a0);
        recv_byte(1'b0, rb);
        chk("R6 read after repeated start", rb == 8'h81, rb, 8'h81);
        do_stop();

        // R7 abort mid byte
        base = stb_cnt;
        do_start();
        send_byte(addr_byte(2'd2, 1'b0), a0);
        send_byte(8'h01, a1);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        do_start();
        send_byte(addr_byte(2'd2, 1'b0), a0);
        chk("R7 new address phase after repeated start", a0 == 1'b1, a0, 1);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        do_stop();
        chk("R7 no strobe for abandoned data", stb_cnt == base, stb_cnt - base, 0);
        chk("R7 selector unchanged", reg_addr == 8'h01, reg_addr, 8'h01);
        chk("R7 register intact", m01 == 8'hC3, m01, 8'hC3);

        // R10 bytes after stop without start
        base = stb_cnt;
        send_byte(addr_byte(2'd2, 1'b0), a0);
        send_byte(8'h00, a1);
        send_byte(8'h55, a2);
        chk("R10 ignored after stop", !a0 && !a1 && !a2, {a0, a1, a2}, 0);
        chk("R10 no strobe after stop", stb_cnt == base, stb_cnt - base, 0);
        do_start();
        do_stop();

        // R8 SDA enable only moves while SCL low
        chk("R8 sda change during scl high", r8_bad == 0, r8_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule